// File: doc/BRIEF.md
# I2C Slave Address Comparator

This block decides whether an I2C slave is being addressed. An upstream bit-level receiver hands it complete bytes together with a marker for each START or repeated START. The first byte after such a marker is the address byte: seven address bits followed by the read/write bit. Only that byte is compared against the programmed slave settings. A match raises a one-cycle pulse, latches the direction, sets a sticky address-match flag and captures the address byte into the data register.

The primary address register holds a 7-bit slave address. A second register holds either a per-bit don't-care mask or a complete alternate address, chosen by a select bit. A promiscuous enable makes every address byte match. For 10-bit addressing, software programs the primary address as `11110` followed by the two upper address bits. The block then recognizes the first address byte in hardware and flags that case. The low eight bits of a 10-bit address are handled outside this block.

Top module: `i2c_addr_cmp`

## Requirements
- R1: After reset, all configuration fields are zero, and `amatch_flag`, `dir_flag`, `data_reg`, `match_pulse` and `tenbit_pulse` are all zero.
- R2: Mask mode (alternate select = 0, promiscuous = 0): an address byte matches when, for every bit i in 0..6, either mask bit i is 1 or byte bit i+1 equals primary address bit i.
- R3: Alternate mode (alternate select = 1, promiscuous = 0): an address byte matches when byte bits 7:1 equal the primary address or equal the second register's address. Partial agreement with either address does not match.
- R4: Promiscuous mode: every evaluated address byte matches, whatever the primary address and the second register hold.
- R5: On a match, in the cycle after the byte is presented: `match_pulse` is 1 for that cycle, `amatch_flag` is 1, `dir_flag` equals byte bit 0, and `data_reg` holds the whole byte.
- R6: Only the first byte presented after an `rx_start` pulse is evaluated. Later bytes before the next `rx_start` never match and change nothing.
- R7: A non-matching address byte leaves `amatch_flag`, `dir_flag` and `data_reg` unchanged and produces no `match_pulse`.
- R8: `amatch_flag` stays set until a `host_data_acc` pulse clears it, or until a host write to offset 2 with data bit 0 = 1 clears it. A match in the same cycle as a clear leaves the flag set.
- R9: `tenbit_pulse` goes high together with `match_pulse` exactly when byte bits 7:3 of the matching byte are `11110`.
- R10: Host register map (`host_addr`): offset 0 = {primary address in bits 7:1, promiscuous enable in bit 0}; offset 1 = {mask or alternate address in bits 7:1, alternate select in bit 0}; offset 2 = flag clear (write-1 to bit 0); writes to offset 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 2 | Host register offset |
| host_wdata | input | 8 | Host write data |
| host_data_acc | input | 1 | Pulse marking a data-register access; clears the match flag |
| rx_start | input | 1 | START or repeated START seen on the bus |
| rx_byte_valid | input | 1 | A received byte is presented this cycle |
| rx_byte | input | 8 | Received byte (bits 7:1 address, bit 0 R/W) |
| match_pulse | output | 1 | One-cycle pulse on an address match |
| tenbit_pulse | output | 1 | Match pulse qualified by the 10-bit prefix |
| amatch_flag | output | 1 | Sticky address-match flag |
| dir_flag | output | 1 | R/W bit of the last matching byte |
| data_reg | output | 8 | Last matching address byte |

## Verification
The assertions check on every cycle that a match pulse always comes with a set flag and a captured byte equal to the byte just presented. They also check that a pulse only follows a presented byte and that the flag only rises on a match. Further, they check that direction and data hold when there is no match, that a clear without a simultaneous match empties the flag, that promiscuous mode always hits an evaluated byte, and that the 10-bit pulse carries the prefix. Only the bench scenarios can show the actual compare results under each mode against the mask and alternate-address rules. The same holds for the rejection of later bytes within one transfer, the ignored offset, and the set-over-clear collision.

// File: rtl/acmp_pkg.sv
package acmp_pkg;
  localparam int ADDR_W   = 7;
  localparam int BYTE_W   = ADDR_W + 1;
  localparam int HOST_AW  = 2;
  localparam int PFX_W    = 5;
  localparam logic [PFX_W-1:0] TENBIT_PFX = 5'b11110;

  localparam logic [HOST_AW-1:0] OFS_PRI = 2'd0;
  localparam logic [HOST_AW-1:0] OFS_SEC = 2'd1;
  localparam logic [HOST_AW-1:0] OFS_CLR = 2'd2;

  typedef struct packed {
    logic [ADDR_W-1:0] pri;
    logic              prom;
    logic [ADDR_W-1:0] sec;
    logic              alt;
  } acmp_cfg_t;

  // per-bit agreement vector: 1 where the bit is masked or equal
  function automatic logic [ADDR_W-1:0] f_bit_agree(
      input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] r,
      input logic [ADDR_W-1:0] m);
    return ~(a ^ r) | m;
  endfunction

  function automatic logic f_full_eq(input logic [ADDR_W-1:0] a,
                                     input logic [ADDR_W-1:0] r);
    return (a == r);
  endfunction

  function automatic logic f_is_tenbit(input logic [BYTE_W-1:0] b);
    return (b[BYTE_W-1 -: PFX_W] == TENBIT_PFX);
  endfunction
endpackage

// File: rtl/acmp_cfg_regs.sv
module acmp_cfg_regs
  import acmp_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [BYTE_W-1:0]  host_wdata,
  output acmp_cfg_t          cfg,
  output logic               clr_w1c
);
  logic wr_pri, wr_sec;

  assign wr_pri  = host_wr && (host_addr == OFS_PRI);
  assign wr_sec  = host_wr && (host_addr == OFS_SEC);
  assign clr_w1c = host_wr && (host_addr == OFS_CLR) && host_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else begin
      if (wr_pri) begin
        cfg.pri  <= host_wdata[BYTE_W-1:1];
        cfg.prom <= host_wdata[0];
      end
      if (wr_sec) begin
        cfg.sec <= host_wdata[BYTE_W-1:1];
        cfg.alt <= host_wdata[0];
      end
    end
  end

  assert_cfg_wr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_pri && !wr_sec) |=> $stable(cfg));
endmodule

// File: rtl/acmp_arm.sv
module acmp_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_start,
  input  logic rx_byte_valid,
  output logic eval_now
);
  logic armed;

  assign eval_now = rx_byte_valid && armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              armed <= 1'b0;
    else if (rx_start)       armed <= 1'b1;
    else if (rx_byte_valid)  armed <= 1'b0;
  end

  assert_arm_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_now && !rx_start) |=> !eval_now);
endmodule

// File: rtl/acmp_compare.sv
module acmp_compare
  import acmp_pkg::*;
(
  input  acmp_cfg_t          cfg,
  input  logic [BYTE_W-1:0]  addr_byte,
  output logic               hit,
  output logic               hit_masked,
  output logic               hit_pair
);
  logic [ADDR_W-1:0] a7;
  logic [ADDR_W-1:0] agree;
  logic [ADDR_W-1:0] eff_mask;

  assign a7       = addr_byte[BYTE_W-1:1];
  assign eff_mask = cfg.alt ? '0 : cfg.sec;

  for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
    assign agree[i] = f_bit_agree(a7, cfg.pri, eff_mask) >> i;
  end

  assign hit_masked = &agree;
  assign hit_pair   = f_full_eq(a7, cfg.pri) || f_full_eq(a7, cfg.sec);

  always_comb begin
    if (cfg.prom)     hit = 1'b1;
    else if (cfg.alt) hit = hit_pair;
    else              hit = hit_masked;
  end
endmodule

// File: rtl/acmp_flags.sv
module acmp_flags
  import acmp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eval_now,
  input  logic              hit,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              clr_req,
  output logic              match_pulse,
  output logic              tenbit_pulse,
  output logic              amatch_flag,
  output logic              dir_flag,
  output logic [BYTE_W-1:0] data_reg
);
  logic set_req;
  assign set_req = eval_now && hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_pulse  <= 1'b0;
      tenbit_pulse <= 1'b0;
      amatch_flag  <= 1'b0;
      dir_flag     <= 1'b0;
      data_reg     <= '0;
    end else begin
      match_pulse  <= set_req;
      tenbit_pulse <= set_req && f_is_tenbit(rx_byte);
      if (set_req) begin
        amatch_flag <= 1'b1;
        dir_flag    <= rx_byte[0];
        data_reg    <= rx_byte;
      end else if (clr_req) begin
        amatch_flag <= 1'b0;
      end
    end
  end

  assert_pulse_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |-> (amatch_flag && dir_flag == data_reg[0]));
  assert_flag_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(amatch_flag) |-> match_pulse);
  assert_hold_nomatch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !match_pulse |-> ($stable(dir_flag) && $stable(data_reg)));
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !set_req) |=> !amatch_flag);
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    set_req |=> amatch_flag);
  assert_tenbit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tenbit_pulse |-> (match_pulse && data_reg[BYTE_W-1 -: PFX_W] == TENBIT_PFX));
endmodule

// File: rtl/i2c_addr_cmp.sv
module i2c_addr_cmp
  import acmp_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [BYTE_W-1:0]  host_wdata,
  input  logic               host_data_acc,
  input  logic               rx_start,
  input  logic               rx_byte_valid,
  input  logic [BYTE_W-1:0]  rx_byte,
  output logic               match_pulse,
  output logic               tenbit_pulse,
  output logic               amatch_flag,
  output logic               dir_flag,
  output logic [BYTE_W-1:0]  data_reg
);
  acmp_cfg_t cfg;
  logic      clr_w1c, clr_req, eval_now, hit, hit_masked, hit_pair;

  assign clr_req = clr_w1c || host_data_acc;

  acmp_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .cfg(cfg), .clr_w1c(clr_w1c));

  acmp_arm u_arm (
    .clk(clk), .rst_n(rst_n), .rx_start(rx_start),
    .rx_byte_valid(rx_byte_valid), .eval_now(eval_now));

  acmp_compare u_cmp (
    .cfg(cfg), .addr_byte(rx_byte), .hit(hit),
    .hit_masked(hit_masked), .hit_pair(hit_pair));

  acmp_flags u_flg (
    .clk(clk), .rst_n(rst_n), .eval_now(eval_now), .hit(hit),
    .rx_byte(rx_byte), .clr_req(clr_req), .match_pulse(match_pulse),
    .tenbit_pulse(tenbit_pulse), .amatch_flag(amatch_flag),
    .dir_flag(dir_flag), .data_reg(data_reg));

  assert_pulse_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |-> ($past(eval_now) && data_reg == $past(rx_byte)));
  assert_prom_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.prom && eval_now) |=> match_pulse);
  assert_alt_exact_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.prom && cfg.alt && eval_now && !hit_pair) |=> !match_pulse);
  assert_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.prom && !cfg.alt && eval_now) |=> (match_pulse == $past(hit_masked)));
endmodule

// File: tb/i2c_addr_cmp_tb_top.sv
module i2c_addr_cmp_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_wr = 0, host_data_acc = 0, rx_start = 0, rx_byte_valid = 0;
  logic [1:0] host_addr = '0;
  logic [7:0] host_wdata = '0, rx_byte = '0;
  logic match_pulse, tenbit_pulse, amatch_flag, dir_flag;
  logic [7:0] data_reg;

  int checks = 0, failures = 0;
  bit done = 0;

  // bench model
  logic [6:0] m_pri = 0, m_sec = 0;
  logic m_prom = 0, m_alt = 0, m_armed = 0;
  logic m_flag = 0, m_dir = 0;
  logic [7:0] m_data = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_addr_cmp dut_i (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_data_acc(host_data_acc),
    .rx_start(rx_start), .rx_byte_valid(rx_byte_valid), .rx_byte(rx_byte),
    .match_pulse(match_pulse), .tenbit_pulse(tenbit_pulse),
    .amatch_flag(amatch_flag), .dir_flag(dir_flag), .data_reg(data_reg));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic model_hit(input logic [7:0] b);
    logic ok;
    if (m_prom) return 1'b1;
    if (m_alt) return (b[7:1] == m_pri) || (b[7:1] == m_sec);
    ok = 1'b1;
    for (int i = 0; i < 7; i++)
      if (!m_sec[i] && (b[i+1] != m_pri[i])) ok = 1'b0;
    return ok;
  endfunction

  task automatic hwrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 0;
    if (a == 2'd0) begin m_pri = d[7:1]; m_prom = d[0]; end
    if (a == 2'd1) begin m_sec = d[7:1]; m_alt = d[0]; end
    if (a == 2'd2 && d[0]) m_flag = 0;
  endtask

  // present byte (optionally after a START), then check all outputs
  task automatic send(input logic [7:0] b, input bit with_start, input string req,
                      input bit acc = 0);
    logic h;
    if (with_start) begin
      @(negedge clk); rx_start = 1;
      @(negedge clk); rx_start = 0;
      m_armed = 1;
    end else @(negedge clk);
    rx_byte_valid = 1; rx_byte = b; host_data_acc = acc;
    h = m_armed && model_hit(b);
    m_armed = 0;
    @(negedge clk);
    rx_byte_valid = 0; host_data_acc = 0;
    if (h) begin m_flag = 1; m_dir = b[0]; m_data = b; end
    else if (acc) m_flag = 0;
    chk({req, " match_pulse"}, {7'd0, match_pulse}, {7'd0, h});
    chk({req, " flag"}, {7'd0, amatch_flag}, {7'd0, m_flag});
    chk({req, " dir"}, {7'd0, dir_flag}, {7'd0, m_dir});
    chk({req, " data"}, data_reg, m_data);
    chk({req, " R9 tenbit"}, {7'd0, tenbit_pulse}, {7'd0, h && b[7:3] == 5'b11110});
  endtask

  task automatic data_access();
    @(negedge clk); host_data_acc = 1;
    @(negedge clk); host_data_acc = 0;
    m_flag = 0;
    chk("R8 access clear", {7'd0, amatch_flag}, 8'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 flag", {7'd0, amatch_flag}, 8'd0);
    chk("R1 dir", {7'd0, dir_flag}, 8'd0);
    chk("R1 data", data_reg, 8'd0);
    chk("R1 pulse", {6'd0, match_pulse, tenbit_pulse}, 8'd0);
    // R1: zero config, mask zero => address 0 matches, others not
    send(8'h02, 1, "R1 zero cfg miss");
    send(8'h01, 1, "R1 zero cfg hit");
    data_access();

    // R2 mask mode directed
    hwrite(2'd0, {7'h55, 1'b0});
    hwrite(2'd1, {7'h03, 1'b0});
    send({7'h56, 1'b1}, 1, "R2 masked low bits hit");
    send({7'h45, 1'b0}, 1, "R2 unmasked diff miss");
    hwrite(2'd1, {7'h7F, 1'b0});
    send(8'h9A, 1, "R2 full mask hit");

    // R8 w1c clear and set-wins collision
    hwrite(2'd2, 8'h01);
    chk("R8 w1c clear", {7'd0, amatch_flag}, 8'd0);
    send(8'h33, 1, "R8 set wins over access", 1);
    hwrite(2'd2, 8'h00);
    chk("R8 w1c bit0 zero keeps", {7'd0, amatch_flag}, 8'd1);
    data_access();

    // R3 alternate mode
    hwrite(2'd0, {7'h21, 1'b0});
    hwrite(2'd1, {7'h4C, 1'b1});
    send({7'h21, 1'b1}, 1, "R3 primary hit");
    send({7'h4C, 1'b0}, 1, "R3 second hit");
    send({7'h4D, 1'b1}, 1, "R3 near miss");
    // R6 later byte without new START ignored
    send({7'h4C, 1'b1}, 1, "R6 first byte");
    send({7'h21, 1'b0}, 0, "R6 later byte");
    // R10 offset 3 ignored
    hwrite(2'd3, 8'hFF);
    send({7'h4C, 1'b1}, 1, "R10 offset3 no effect hit");
    send({7'h7F, 1'b1}, 1, "R10 offset3 no effect miss");

    // R4 promiscuous
    hwrite(2'd0, {7'h21, 1'b1});
    send(8'hE7, 1, "R4 prom any");
    send(8'h00, 1, "R4 prom zero");
    send(8'h11, 0, "R4 R6 prom no start");

    // R9 10-bit prefix
    hwrite(2'd0, {7'b1111010, 1'b0});
    hwrite(2'd1, {7'h00, 1'b0});
    send({7'b1111010, 1'b0}, 1, "R9 prefix hit");
    send({7'b1111011, 1'b0}, 1, "R9 prefix other hi bits miss");
    data_access();

    // random mixed
    for (int it = 0; it < 300; it++) begin
      logic [7:0] b;
      int op;
      op = $urandom_range(0, 9);
      if (op == 0) hwrite(2'd0, 8'($urandom) & 8'hFE | 8'(($urandom_range(0, 7) == 0)));
      else if (op == 1) hwrite(2'd1, 8'($urandom));
      else if (op == 2) data_access();
      else if (op == 3) hwrite(2'd2, 8'($urandom));
      else begin
        b = 8'($urandom);
        if ($urandom_range(0, 2) == 0) b = {m_pri, b[0]};
        else if ($urandom_range(0, 2) == 0) b = {m_sec, b[0]};
        send(b, ($urandom_range(0, 4) != 0), "R2 R3 R4 R5 R7 random");
      end
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule